// File: doc/BRIEF.md
# Audio serial clock generation unit

This block produces the bit clocks, word-select routing and master-clock outputs for the transmit and receive halves of a stereo audio serial port. Each half picks a master clock from one of two level inputs, the fractional-rate divider outputs for transmit and receive, which are assumed to be already synchronous to the system clock `clk`. It divides that master clock by a programmable integer to make its bit clock. The divider counts both edges of the master clock, so every divide ratio, odd ones included, gives an exact 50% duty cycle.

A shared-pin mode lets one half borrow the other half's bit clock and word select, so that a four-wire link is driven from one clock pair. A per-half enable gates the selected master clock onto an output pin together with its output-enable. Four 32-bit registers, written through a simple synchronous write port and read back combinationally, hold the configuration.

Top module: `aud_clk_gen`

## Requirements
- R1: The bit clock of each half toggles after every (rate+1) edges of its selected master clock, where rate is the 6-bit value in bits [5:0] of its rate register. Its period is (rate+1) master periods with a duty cycle of exactly 50%.
- R2: After reset both rate registers and both mode registers read 0, and all bit clocks and master-clock outputs are low. With rate 0 the bit clock equals the selected master clock delayed by one `clk` cycle.
- R3: Transmit mode bits [1:0] select the transmit master clock. Code 2 picks the receive fractional input. Codes 0, 1 and 3 pick the transmit fractional input.
- R4: Receive mode bits [1:0] select the receive master clock. Code 2 picks the transmit fractional input. Codes 0, 1 and 3 pick the receive fractional input.
- R5: When transmit mode bit 2 is 1, `tx_sck` and `tx_ws` carry the receive half's own bit clock and `rx_ws_src`.
- R6: When receive mode bit 2 is 1 and transmit mode bit 2 is 0, `rx_sck` and `rx_ws` carry the transmit half's own bit clock and `tx_ws_src`. When both bits are 1, only the transmit half borrows and the receive half keeps its own.
- R7: Mode bit 3 enables a half's master-clock output. The output-enable pin and the gated clock are both registered one cycle behind, so the output equals (enable AND selected master clock) from the previous cycle. The output is low whenever its output-enable is low.
- R8: Register addresses are 0 for the transmit rate, 1 for the receive rate, 2 for the transmit mode and 3 for the receive mode. Reads return the field bits and zeros elsewhere. Writes to reserved bits have no effect.
- R9: A write to a rate register clears that half's divider. Its own bit clock is low in the next cycle, and counting restarts from the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 32 | Register read data (combinational) |
| tx_frac_mclk | input | 1 | Transmit fractional-rate master clock level |
| rx_frac_mclk | input | 1 | Receive fractional-rate master clock level |
| tx_ws_src | input | 1 | Transmit word select from framing logic |
| rx_ws_src | input | 1 | Receive word select from framing logic |
| tx_sck | output | 1 | Transmit bit clock |
| tx_ws | output | 1 | Transmit word select after sharing |
| rx_sck | output | 1 | Receive bit clock |
| rx_ws | output | 1 | Receive word select after sharing |
| tx_mclk_out | output | 1 | Gated transmit master clock |
| tx_mclk_oe | output | 1 | Transmit master clock output enable |
| rx_mclk_out | output | 1 | Gated receive master clock |
| rx_mclk_oe | output | 1 | Receive master clock output enable |

## Verification
Two events can land in the same cycle: a rate-register write, which restarts the divider, and a master-clock edge, which advances the count or toggles the output. The bench sweeps the write over every phase of the master clock, so the write coincides with an edge at least once, and then requires the restart to win with the bit clock low in the next cycle. A second collision comes from changing the master-clock enable while the selected clock is high. In both cases the outputs are compared on every clock against a behavioural model, which decides what each output should be in every cycle.

// File: rtl/aud_clk_pkg.sv
// Package: shared register addresses and the mode-register field layout
// for the audio serial clock generation unit.
package aud_clk_pkg;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] A_TX_RATE = 2'd0;
    localparam logic [ADDR_W-1:0] A_RX_RATE = 2'd1;
    localparam logic [ADDR_W-1:0] A_TX_MODE = 2'd2;
    localparam logic [ADDR_W-1:0] A_RX_MODE = 2'd3;

    // Source code that picks the opposite half's fractional input.
    localparam logic [1:0] SRC_CROSS = 2'd2;

    // Mode register, bits [3:0]: output enable, shared pins, source select.
    typedef struct packed {
        logic       mclk_en;
        logic       share;
        logic [1:0] src_sel;
    } mode_t;

    localparam int MODE_W = $bits(mode_t);
endpackage

// File: rtl/aud_clk_regs.sv
// Module: configuration registers. Holds both rate fields and both mode
// fields, issues a one-cycle restart pulse for a half when its rate register
// is written, and returns zeros for every reserved bit on read.
// Assumes: wr_* inputs are synchronous to clk.
module aud_clk_regs
    import aud_clk_pkg::*;
#(
    parameter int RATE_W = 6,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [RATE_W-1:0] tx_rate,
    output logic [RATE_W-1:0] rx_rate,
    output mode_t             tx_mode,
    output mode_t             rx_mode,
    output logic              tx_restart,
    output logic              rx_restart
);
    // Write decode: a rate write restarts its divider in the same cycle.
    always_comb begin
        tx_restart = wr_en && (wr_addr == A_TX_RATE);
        rx_restart = wr_en && (wr_addr == A_RX_RATE);
    end

    // Register update; only the field bits are stored.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_rate <= '0;
            rx_rate <= '0;
            tx_mode <= '0;
            rx_mode <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                A_TX_RATE: tx_rate <= wr_data[RATE_W-1:0];
                A_RX_RATE: rx_rate <= wr_data[RATE_W-1:0];
                A_TX_MODE: tx_mode <= mode_t'(wr_data[MODE_W-1:0]);
                default:   rx_mode <= mode_t'(wr_data[MODE_W-1:0]);
            endcase
        end
    end

    // Read mux, zero-extending every field.
    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_TX_RATE: rd_data[RATE_W-1:0] = tx_rate;
            A_RX_RATE: rd_data[RATE_W-1:0] = rx_rate;
            A_TX_MODE: rd_data[MODE_W-1:0] = tx_mode;
            default:   rd_data[MODE_W-1:0] = rx_mode;
        endcase
    end
endmodule

// File: rtl/aud_clk_div.sv
// Module: edge-counting bit-clock divider. It counts both edges of a
// level-sampled master clock and toggles its output after rate+1 edges, so
// the output period is rate+1 master periods at a 50% duty cycle for any ratio.
// Assumes: mclk is synchronous to clk and holds each level for at least one cycle.
module aud_clk_div #(
    parameter int RATE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mclk,
    input  logic [RATE_W-1:0] rate,
    input  logic              restart,
    output logic              sck
);
    logic              mclk_prev;
    logic [RATE_W-1:0] edge_cnt;
    logic              mclk_edge;

    // Edge detect on the sampled master clock level.
    always_comb mclk_edge = (mclk != mclk_prev);

    // Edge counter and output toggle; restart takes priority over an edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mclk_prev <= 1'b0;
            edge_cnt  <= '0;
            sck       <= 1'b0;
        end else begin
            mclk_prev <= mclk;
            if (restart) begin
                edge_cnt <= '0;
                sck      <= 1'b0;
            end else if (mclk_edge) begin
                if (edge_cnt >= rate) begin
                    edge_cnt <= '0;
                    sck      <= ~sck;
                end else begin
                    edge_cnt <= edge_cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/aud_clk_mgate.sv
// Module: master-clock output gate. It registers the enable and the gated
// clock on the same edge, so the pin and its enable cannot glitch and the pin
// is low whenever the enable is low.
// Assumes: src is synchronous to clk.
module aud_clk_mgate (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic src,
    output logic mclk_out,
    output logic mclk_oe
);
    // Registered gate and enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mclk_out <= 1'b0;
            mclk_oe  <= 1'b0;
        end else begin
            mclk_out <= en & src;
            mclk_oe  <= en;
        end
    end
endmodule

// File: rtl/aud_clk_gen.sv
// Module: top of the audio serial clock generation unit. It selects each
// half's master clock, divides it into a bit clock, applies shared-pin routing
// to the bit clocks and word selects, and gates the master clocks onto pins.
// Assumes: both fractional master clock inputs and both word-select inputs
// are synchronous to clk. Each half's cross-select reads the other half's raw
// fractional input, never the other half's selected clock, so no loop can form.
module aud_clk_gen
    import aud_clk_pkg::*;
#(
    parameter int RATE_W = 6,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              tx_frac_mclk,
    input  logic              rx_frac_mclk,
    input  logic              tx_ws_src,
    input  logic              rx_ws_src,
    output logic              tx_sck,
    output logic              tx_ws,
    output logic              rx_sck,
    output logic              rx_ws,
    output logic              tx_mclk_out,
    output logic              tx_mclk_oe,
    output logic              rx_mclk_out,
    output logic              rx_mclk_oe
);
    localparam int NDIR = 2;   // index 0 = transmit, 1 = receive

    logic [RATE_W-1:0] tx_rate, rx_rate;
    mode_t             tx_mode, rx_mode;
    logic              tx_restart, rx_restart;

    logic [RATE_W-1:0] rate_a    [NDIR];
    mode_t             mode_a    [NDIR];
    logic [NDIR-1:0]   restart_a;
    logic [NDIR-1:0]   own_frac;
    logic [NDIR-1:0]   other_frac;
    logic [NDIR-1:0]   sel_mclk;
    logic [NDIR-1:0]   own_sck;
    logic [NDIR-1:0]   mout_a;
    logic [NDIR-1:0]   moe_a;
    logic              tx_share, rx_share;

    aud_clk_regs #(.RATE_W(RATE_W), .DATA_W(DATA_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data),
        .tx_rate    (tx_rate),
        .rx_rate    (rx_rate),
        .tx_mode    (tx_mode),
        .rx_mode    (rx_mode),
        .tx_restart (tx_restart),
        .rx_restart (rx_restart)
    );

    // Gather per-half controls into arrays for the generate loop.
    always_comb begin
        rate_a[0]  = tx_rate;
        rate_a[1]  = rx_rate;
        mode_a[0]  = tx_mode;
        mode_a[1]  = rx_mode;
        restart_a  = {rx_restart, tx_restart};
        own_frac   = {rx_frac_mclk, tx_frac_mclk};
        other_frac = {tx_frac_mclk, rx_frac_mclk};
    end

    for (genvar d = 0; d < NDIR; d++) begin : g_dir
        // Source select; reserved codes fall back to the own input.
        always_comb sel_mclk[d] = (mode_a[d].src_sel == SRC_CROSS) ?
                                  other_frac[d] : own_frac[d];

        aud_clk_div #(.RATE_W(RATE_W)) u_div (
            .clk     (clk),
            .rst_n   (rst_n),
            .mclk    (sel_mclk[d]),
            .rate    (rate_a[d]),
            .restart (restart_a[d]),
            .sck     (own_sck[d])
        );

        aud_clk_mgate u_gate (
            .clk      (clk),
            .rst_n    (rst_n),
            .en       (mode_a[d].mclk_en),
            .src      (sel_mclk[d]),
            .mclk_out (mout_a[d]),
            .mclk_oe  (moe_a[d])
        );
    end

    // Shared-pin routing; transmit borrowing wins when both ask.
    always_comb begin
        tx_share    = tx_mode.share;
        rx_share    = rx_mode.share & ~tx_mode.share;
        tx_sck      = tx_share ? own_sck[1] : own_sck[0];
        tx_ws       = tx_share ? rx_ws_src  : tx_ws_src;
        rx_sck      = rx_share ? own_sck[0] : own_sck[1];
        rx_ws       = rx_share ? tx_ws_src  : rx_ws_src;
        tx_mclk_out = mout_a[0];
        tx_mclk_oe  = moe_a[0];
        rx_mclk_out = mout_a[1];
        rx_mclk_oe  = moe_a[1];
    end
endmodule

// File: rtl/aud_clk_gen_chk.sv
// Module: assertion checker bound to aud_clk_gen. It observes ports and the
// registered share controls only.
module aud_clk_gen_chk
    import aud_clk_pkg::*;
#(
    parameter int RATE_W = 6,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] rd_data,
    input logic              tx_sck,
    input logic              rx_sck,
    input logic              tx_ws,
    input logic              rx_ws,
    input logic              rx_ws_src,
    input logic              tx_mclk_out,
    input logic              tx_mclk_oe,
    input logic              rx_mclk_out,
    input logic              rx_mclk_oe,
    input logic              tx_share
);
    // R7
    tx_mclk_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_mclk_oe |-> !tx_mclk_out);
    // R7
    rx_mclk_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_mclk_oe |-> !rx_mclk_out);
    // R8
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[DATA_W-1:RATE_W] == '0);
    // R5
    tx_share_sck_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_share |-> (tx_sck == rx_sck) && (tx_ws == rx_ws_src));
    // R9
    tx_restart_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_TX_RATE && !tx_share) |=> !tx_sck);
endmodule

bind aud_clk_gen aud_clk_gen_chk #(.RATE_W(RATE_W), .DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .rd_data     (rd_data),
    .tx_sck      (tx_sck),
    .rx_sck      (rx_sck),
    .tx_ws       (tx_ws),
    .rx_ws       (rx_ws),
    .rx_ws_src   (rx_ws_src),
    .tx_mclk_out (tx_mclk_out),
    .tx_mclk_oe  (tx_mclk_oe),
    .rx_mclk_out (rx_mclk_out),
    .rx_mclk_oe  (rx_mclk_oe),
    .tx_share    (tx_share)
);

// File: tb/sim_aud_clk_gen.sv
// Bench: behavioural reference model of both halves, compared on every
// falling clock edge; inputs change only right after that comparison.
module sim_aud_clk_gen;
    localparam int CLK_NS = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        tx_frac_mclk = 1'b0, rx_frac_mclk = 1'b0;
    logic        tx_ws_src = 1'b0, rx_ws_src = 1'b0;
    logic        tx_sck, tx_ws, rx_sck, rx_ws;
    logic        tx_mclk_out, tx_mclk_oe, rx_mclk_out, rx_mclk_oe;

    int checks = 0;
    int errors = 0;
    string tag = "R2";

    // model state, index 0 = transmit, 1 = receive
    int m_rate[2], m_sel[2], m_sh[2], m_en[2];
    int m_prev[2], m_cnt[2], m_q[2], m_mo[2], m_oe[2];
    int half_t = 2, half_r = 3, ct = 0, cr = 0, cyc_n = 0;

    always #(CLK_NS/2) clk = ~clk;

    aud_clk_gen u0 (.*);

    function automatic int src_of(int d);
        if (d == 0) return (m_sel[0] == 2) ? int'(rx_frac_mclk) : int'(tx_frac_mclk);
        return (m_sel[1] == 2) ? int'(tx_frac_mclk) : int'(rx_frac_mclk);
    endfunction

    // model step on each rising edge, using the inputs the bench is applying
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int d = 0; d < 2; d++) begin
                m_rate[d] = 0; m_sel[d] = 0; m_sh[d] = 0; m_en[d] = 0;
                m_prev[d] = 0; m_cnt[d] = 0; m_q[d] = 0; m_mo[d] = 0; m_oe[d] = 0;
            end
        end else begin
            for (int d = 0; d < 2; d++) begin
                int s;
                s = src_of(d);
                m_mo[d] = m_en[d] & s;
                m_oe[d] = m_en[d];
                if (wr_en && wr_addr == d[1:0]) begin
                    m_cnt[d] = 0; m_q[d] = 0;
                end else if (s != m_prev[d]) begin
                    if (m_cnt[d] >= m_rate[d]) begin
                        m_cnt[d] = 0; m_q[d] ^= 1;
                    end else m_cnt[d]++;
                end
                m_prev[d] = s;
            end
            if (wr_en) begin
                if (wr_addr < 2) m_rate[wr_addr] = int'(wr_data[5:0]);
                else begin
                    m_sel[wr_addr-2] = int'(wr_data[1:0]);
                    m_sh[wr_addr-2]  = int'(wr_data[2]);
                    m_en[wr_addr-2]  = int'(wr_data[3]);
                end
            end
        end
    end

    task automatic chk(string r, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", r, what, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        int tsh, rsh, e_tsck, e_rsck, e_tws, e_rws, e_rd;
        tsh = m_sh[0];
        rsh = m_sh[1] & ~m_sh[0];
        e_tsck = tsh ? m_q[1] : m_q[0];
        e_rsck = rsh ? m_q[0] : m_q[1];
        e_tws  = tsh ? int'(rx_ws_src) : int'(tx_ws_src);
        e_rws  = rsh ? int'(tx_ws_src) : int'(rx_ws_src);
        if (rd_addr < 2) e_rd = m_rate[rd_addr];
        else e_rd = m_en[rd_addr-2]*8 + m_sh[rd_addr-2]*4 + m_sel[rd_addr-2];
        chk({tag, "/R1"}, "tx_sck", 32'(tx_sck), 32'(e_tsck));
        chk({tag, "/R1"}, "rx_sck", 32'(rx_sck), 32'(e_rsck));
        chk({tag, "/R5"}, "tx_ws", 32'(tx_ws), 32'(e_tws));
        chk({tag, "/R6"}, "rx_ws", 32'(rx_ws), 32'(e_rws));
        chk({tag, "/R7"}, "tx_mclk", {30'd0, tx_mclk_oe, tx_mclk_out}, 32'(m_oe[0]*2 + m_mo[0]));
        chk({tag, "/R7"}, "rx_mclk", {30'd0, rx_mclk_oe, rx_mclk_out}, 32'(m_oe[1]*2 + m_mo[1]));
        chk({tag, "/R8"}, "rd_data", rd_data, 32'(e_rd));
    endtask

    // one cycle: compare at the falling edge, then move the stimulus
    task automatic cyc();
        @(negedge clk);
        compare_all();
        cyc_n++;
        if (++ct >= half_t) begin ct = 0; tx_frac_mclk = ~tx_frac_mclk; end
        if (++cr >= half_r) begin cr = 0; rx_frac_mclk = ~rx_frac_mclk; end
        if (cyc_n % 7 == 0) tx_ws_src = $urandom_range(0, 1);
        if (cyc_n % 5 == 0) rx_ws_src = $urandom_range(0, 1);
        rd_addr = rd_addr + 2'd1;
    endtask

    task automatic wr(logic [1:0] a, logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        cyc();
        wr_en = 1'b0;
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    initial begin : watchdog
        #(CLK_NS * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        int high;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R2: reset values and divide-by-one
        tag = "R2";
        for (int a = 0; a < 4; a++) begin
            rd_addr = a[1:0];
            #1 chk("R2", "reset rd", rd_data, 32'd0);
        end
        chk("R2", "reset outs", {26'd0, tx_sck, rx_sck, tx_mclk_out, tx_mclk_oe, rx_mclk_out, rx_mclk_oe}, 32'd0);
        run(60);
        // R8: reserved bits ignored and read as zero
        tag = "R8";
        wr(2'd0, 32'hFFFF_FFC1);
        wr(2'd2, 32'hFFFF_FFF0);
        run(40);
        // R1: divide ratios, odd ones included
        tag = "R1";
        wr(2'd0, 32'd2);
        wr(2'd1, 32'd5);
        run(200);
        wr(2'd2, 32'd0);
        wr(2'd0, 32'd2);
        high = 0;
        for (int i = 0; i < 240; i++) begin cyc(); high += int'(tx_sck); end
        chk("R1", "tx_sck duty high count", 32'(high), 32'd120);
        // R3: transmit source codes, reserved ones fall back
        tag = "R3";
        for (int c = 0; c < 4; c++) begin wr(2'd2, 32'(c)); run(90); end
        // R4: receive source codes
        tag = "R4";
        wr(2'd1, 32'd1);
        for (int c = 0; c < 4; c++) begin wr(2'd3, 32'(c)); run(90); end
        // R5: transmit borrows receive pins
        tag = "R5";
        wr(2'd3, 32'd0);
        wr(2'd2, 32'd4);
        run(120);
        // R6: receive borrows, then both set
        tag = "R6";
        wr(2'd2, 32'd0);
        wr(2'd3, 32'd4);
        run(120);
        wr(2'd2, 32'd4);
        run(120);
        // R7: master clock gating, enable toggled at varied phases
        tag = "R7";
        wr(2'd2, 32'd0);
        wr(2'd3, 32'd0);
        for (int p = 0; p < 8; p++) begin
            wr(2'd2, 32'h8 | 32'(p & 2));
            wr(2'd3, 32'h8);
            run(p + 3);
            wr(2'd2, 32'd0);
            run(p + 1);
            wr(2'd3, 32'd0);
        end
        // R9: rate write landing on every master-clock phase
        tag = "R9";
        half_t = 3;
        for (int p = 0; p < 12; p++) begin
            wr(2'd0, 32'(p % 3));
            run(p + 4);
        end
        run(100);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule